// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital sequencer of a dual-slope integrating analog-to-digital converter. The integrator, the comparator and the analog switches sit outside it. The block drives three switch enables and reads a single comparator bit. One binary counter serves two purposes. It first times a fixed run-up interval, during which the unknown voltage is integrated. It is then cleared and counts the run-down interval, during which the opposite-polarity reference brings the integrator back to zero.

A conversion starts with a pulse on `start`. The capacitor-discharge switch is closed for a programmable number of cycles. The input switch is then closed for exactly `N_REF` cycles, and after that the reference switch is closed. When the synchronized comparator reports that the integrator output is no longer above zero, the counter stops. The count it holds becomes the result, which is proportional to `N_REF` times the input-to-reference ratio. If the counter reaches full scale first, the result saturates and an overrange flag is raised.

Top module: `dsadc_ctrl`

## Requirements
- R1: During and right after synchronous reset, all three switch outputs, `busy`, `done`, `result` and `overrange` are 0.
- R2: A `start` sampled high while idle closes `sw_reset` from the next cycle. It stays closed for `settle_len` cycles, or for 1 cycle when `settle_len` is 0, and `sw_input` and `sw_ref` stay open during that time.
- R3: Directly after the discharge interval, `sw_input` is closed for exactly `N_REF` cycles and is the only switch closed.
- R4: Directly after run-up, `sw_ref` is closed until the conversion stops. No more than one switch is ever closed in any cycle.
- R5: The comparator passes through a two-flop synchronizer. The run-down counter holds 0 in the first run-down cycle and increments once per cycle. The first run-down cycle in which the synchronized comparator reads 0 is the stopping cycle, and the counter value in that cycle becomes `result`.
- R6: `done` is high for exactly one cycle, the cycle after the stopping cycle. In that same cycle `busy` falls and the new `result` and `overrange` values appear. Both values then hold until the next `done`.
- R7: If the counter reaches 2^CNT_W-1 while the synchronized comparator still reads 1, the conversion stops with `result` = 2^CNT_W-1 and `overrange` = 1. Any other stop clears `overrange` to 0.
- R8: A `start` that arrives while `busy` is high is ignored and does not queue a later conversion.
- R9: With an ideal integrator that gains `vin` per run-up cycle and loses `vref` per run-down cycle, a result that is not overranged lies between floor(N_REF*vin/vref) and that value plus 3.
- R10: `busy` is high from the cycle after an accepted `start` up to and including the stopping cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion when idle |
| settle_len | input | SET_W | Length of the discharge interval in cycles (0 means 1) |
| cmp_pos | input | 1 | Asynchronous comparator: 1 while the integrator is above zero |
| sw_reset | output | 1 | Close the capacitor-discharge switch |
| sw_input | output | 1 | Route the unknown input to the integrator |
| sw_ref | output | 1 | Route the reference to the integrator |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle pulse when a new result is available |
| result | output | CNT_W | Run-down count of the last conversion |
| overrange | output | 1 | The last conversion saturated |

## Verification
A wrong phase register shows up on the switch outputs in the very cycle it goes wrong. A counter that is off by one stretches or shortens the discharge or run-up window, and the bench catches this at the first mismatched switch edge. A fault in the synchronizer path or in the stopping logic shifts `result` and the timing of `done` by whole cycles, so the bench sees it at the end of the affected conversion. Conversions chosen just below and above full scale show whether the saturation path and the overrange flag are taken on the right side of that boundary.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_SETTLE   = 2'd1,
        PH_RUNUP    = 2'd2,
        PH_RUNDOWN  = 2'd3
    } phase_e;

    typedef struct packed {
        logic discharge;
        logic pick_input;
        logic pick_ref;
    } sw_t;

    function automatic sw_t phase_switches(phase_e ph);
        sw_t s;
        s = '0;
        case (ph)
            PH_SETTLE:  s.discharge  = 1'b1;
            PH_RUNUP:   s.pick_input = 1'b1;
            PH_RUNDOWN: s.pick_ref   = 1'b1;
            default:    s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q,
    output logic         at_max
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (en)    q <= q + 1'b1;
    end

    assign at_max = &q;

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && en && !at_max) |=> (q == $past(q) + 1'b1));
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm import dsadc_pkg::*; #(
    parameter int CNT_W = 8,
    parameter int SET_W = 4,
    parameter int N_REF = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SET_W-1:0] settle_len,
    input  logic             cmp_hi,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_max,
    output logic             cnt_clr,
    output logic             cnt_en,
    output phase_e           phase,
    output logic             done,
    output logic [CNT_W-1:0] result,
    output logic             overrange
);
    localparam int RUNUP_LAST = N_REF - 1;

    phase_e           phase_q, phase_d;
    logic [SET_W-1:0] eff_len;
    logic             settle_last, runup_last;
    logic             finish, finish_ovr;

    assign eff_len     = (settle_len == '0) ? SET_W'(1) : settle_len;
    assign settle_last = (32'(cnt) == 32'(eff_len) - 32'd1);
    assign runup_last  = (32'(cnt) == 32'(RUNUP_LAST));

    always_comb begin
        phase_d    = phase_q;
        cnt_clr    = 1'b0;
        cnt_en     = 1'b0;
        finish     = 1'b0;
        finish_ovr = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                cnt_clr = 1'b1;
                if (start) phase_d = PH_SETTLE;
            end
            PH_SETTLE: begin
                if (settle_last) begin
                    phase_d = PH_RUNUP;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            PH_RUNUP: begin
                if (runup_last) begin
                    phase_d = PH_RUNDOWN;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            PH_RUNDOWN: begin
                if (!cmp_hi) begin
                    finish = 1'b1;
                end else if (cnt_max) begin
                    finish     = 1'b1;
                    finish_ovr = 1'b1;
                end else begin
                    cnt_en = 1'b1;
                end
                if (finish) begin
                    phase_d = PH_IDLE;
                    cnt_clr = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            done      <= 1'b0;
            result    <= '0;
            overrange <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done    <= finish;
            if (finish) begin
                result    <= finish_ovr ? '1 : cnt;
                overrange <= finish_ovr;
            end
        end
    end

    assign phase = phase_q;

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && start) |=> (phase_q == PH_SETTLE));

    // R5
    rundown_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUNDOWN && $past(phase_q) == PH_RUNUP) |-> (cnt == '0));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    ovr_full_chk: assert property (@(posedge clk) disable iff (rst)
        overrange |-> (&result));
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl import dsadc_pkg::*; #(
    parameter int CNT_W = 8,
    parameter int SET_W = 4,
    parameter int N_REF = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SET_W-1:0] settle_len,
    input  logic             cmp_pos,
    output logic             sw_reset,
    output logic             sw_input,
    output logic             sw_ref,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] result,
    output logic             overrange
);
    localparam int SYNC_STAGES = 2;

    logic             cmp_s;
    logic [CNT_W-1:0] cnt;
    logic             cnt_max, cnt_clr, cnt_en;
    phase_e           phase;
    sw_t              sw;

    dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_pos),
        .q   (cmp_s)
    );

    dsadc_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (cnt_clr),
        .en     (cnt_en),
        .q      (cnt),
        .at_max (cnt_max)
    );

    dsadc_fsm #(.CNT_W(CNT_W), .SET_W(SET_W), .N_REF(N_REF)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .settle_len (settle_len),
        .cmp_hi     (cmp_s),
        .cnt        (cnt),
        .cnt_max    (cnt_max),
        .cnt_clr    (cnt_clr),
        .cnt_en     (cnt_en),
        .phase      (phase),
        .done       (done),
        .result     (result),
        .overrange  (overrange)
    );

    assign sw       = phase_switches(phase);
    assign sw_reset = sw.discharge;
    assign sw_input = sw.pick_input;
    assign sw_ref   = sw.pick_ref;
    assign busy     = (phase != PH_IDLE);

    // R4
    sw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sw_reset, sw_input, sw_ref}));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/dsadc_ctrl_bench.sv
module dsadc_ctrl_bench;
    localparam int CNT_W = 8;
    localparam int SET_W = 4;
    localparam int N_REF = 100;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [SET_W-1:0] settle_len = '0;
    logic             cmp_pos = 1'b0;
    logic             sw_reset, sw_input, sw_ref, busy, done, overrange;
    logic [CNT_W-1:0] result;

    int tests = 0;
    int fails = 0;
    bit ended = 0;
    int vin = 0;
    int vref = 1;
    int vint = 0;
    int n_done = 0;

    // behavioural reference model state
    int m_ph = 0;
    int m_cnt = 0;
    bit m_q1 = 0, m_q2 = 0;
    bit m_done = 0;
    int m_res = 0;
    bit m_ovr = 0;

    always #4 clk = ~clk;

    dsadc_ctrl #(.CNT_W(CNT_W), .SET_W(SET_W), .N_REF(N_REF)) u_dsadc_ctrl (
        .clk, .rst, .start, .settle_len, .cmp_pos,
        .sw_reset, .sw_input, .sw_ref, .busy, .done, .result, .overrange
    );

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        bit q2_old;
        int len;
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_q1 = 0; m_q2 = 0;
            m_done = 0; m_res = 0; m_ovr = 0;
        end else begin
            q2_old = m_q2;
            m_q2 = m_q1;
            m_q1 = cmp_pos;
            m_done = 0;
            len = (settle_len == 0) ? 1 : int'(settle_len);
            case (m_ph)
                0: if (start) begin m_ph = 1; m_cnt = 0; end
                1: if (m_cnt == len - 1) begin m_ph = 2; m_cnt = 0; end
                   else m_cnt++;
                2: if (m_cnt == N_REF - 1) begin m_ph = 3; m_cnt = 0; end
                   else m_cnt++;
                default: begin
                    if (!q2_old) begin
                        m_res = m_cnt; m_ovr = 0; m_done = 1; m_ph = 0; m_cnt = 0;
                    end else if (m_cnt == MAXC) begin
                        m_res = MAXC; m_ovr = 1; m_done = 1; m_ph = 0; m_cnt = 0;
                    end else begin
                        m_cnt++;
                    end
                end
            endcase
        end
    end

    // per-cycle comparison, then the integrator plant
    always @(negedge clk) begin
        int ideal;
        if (!rst) begin
            chk("R10 busy", int'(busy), int'(m_ph != 0));
            chk("R2 sw_reset", int'(sw_reset), int'(m_ph == 1));
            chk("R3 sw_input", int'(sw_input), int'(m_ph == 2));
            chk("R4 sw_ref", int'(sw_ref), int'(m_ph == 3));
            chk("R6 done", int'(done), int'(m_done));
            chk("R5 result", int'(result), m_res);
            chk("R7 overrange", int'(overrange), int'(m_ovr));
            if (done) begin
                n_done++;
                if (!overrange) begin
                    ideal = (N_REF * vin) / vref;
                    chk("R9 ratiometric result",
                        int'(result),
                        (int'(result) >= ideal && int'(result) <= ideal + 3) ? int'(result) : ideal);
                end
            end
        end
        if (sw_reset)      vint = 0;
        else if (sw_input) vint += vin;
        else if (sw_ref)   vint -= vref;
        cmp_pos = (vint > 0);
    end

    task automatic wait_done();
        int old;
        old = n_done;
        for (int k = 0; k < 2000 && n_done == old; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic convert(int a, int r, int s);
        vin = a; vref = r; settle_len = SET_W'(s);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sw_reset", int'(sw_reset), 0);
        chk("R1 sw_input", int'(sw_input), 0);
        chk("R1 sw_ref", int'(sw_ref), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 result", int'(result), 0);
        chk("R1 overrange", int'(overrange), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        convert(30, 40, 3);
        chk("R5 mid-scale result", int'(result), 76);
        convert(0, 40, 5);
        chk("R5 zero input", int'(result), 0);
        convert(7, 50, 0);
        convert(7, 50, 15);
        convert(100, 40, 2);
        chk("R7 just below full scale", int'(overrange), 0);
        chk("R5 just below full scale", int'(result), 251);
        convert(120, 40, 2);
        chk("R7 saturated flag", int'(overrange), 1);
        chk("R7 saturated result", int'(result), MAXC);
        convert(1, 40, 1);
        chk("R7 flag cleared", int'(overrange), 0);

        // R8: start pulses while busy are ignored
        vin = 20; vref = 40; settle_len = SET_W'(4);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (105) @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        chk("R8 no queued conversion", int'(busy), 0);
        repeat (5) @(negedge clk);
        chk("R8 still idle", int'(busy), 0);

        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule